// File: doc/BRIEF.md
# Tagged Receive FIFO with End/Error Window

This block buffers received bytes from a serial link's deserializer. Each byte is stored with three condition tags: end of frame, CRC error and overrun. The tags of the oldest entry, the one at the read end, appear at the outputs as status flags. Software can therefore see whether the next byte closes a frame or is damaged before it reads that byte. Reading the data port returns the oldest byte and advances the FIFO, so the next entry's tags move into the status flags.

A summary flag watches the oldest eight valid entries. If any of them carries a tag, the interrupt output is raised and DMA service requests are held off. Software then drains the tagged bytes by hand. When the last tagged byte leaves the window, DMA requests resume without any software action. A push into a full FIFO is dropped, and the loss is recorded as an overrun tag on the newest stored byte. A read of an empty FIFO sets a sticky underflow flag.

Occupancy is tracked by a state machine with four named states:
- `S_EMPTY` holds no entries.
- `S_LOW` holds 1 to 7 entries.
- `S_HIGH` holds 8 to 15 entries.
- `S_FULL` holds 16 entries.

The state follows the entry count after each clock edge. Its named transitions are:
- `fill_start`: `S_EMPTY` to `S_LOW`.
- `reach_level`: `S_LOW` to `S_HIGH`.
- `fill_last`: `S_HIGH` to `S_FULL`.
- `drain_one`: `S_FULL` to `S_HIGH`.
- `drop_level`: `S_HIGH` to `S_LOW`.
- `drain_out`: `S_LOW` to `S_EMPTY`.

In every state, a cycle whose push and pop balance keeps the state where it is.

Top module: `rxtag_fifo`

## Requirements
- R1: Each entry is 11 bits, laid out as follows:
  - data in bits 0–7;
  - end of frame in bit 8;
  - CRC error in bit 9;
  - overrun in bit 10.
  
  A push stores the byte and its tags together, and reads return the bytes in push order.
- R2: `st_eof`, `st_crc`, `st_ovr` equal the tags of the oldest entry, or 0 when the FIFO is empty. After a read they show the next entry's tags.
- R3: `rd_data` presents the oldest byte, and a cycle with `rd_en` high removes it. A read of an empty FIFO returns 0, moves nothing and sets the sticky `st_underflow`. `st_underflow` is cleared only by a cycle with `clr_underflow` = 1. If a set and a clear fall in the same cycle, the set wins.
- R4: `st_eif` is 1 exactly when some tag bit is set in one of the oldest min(8, count) entries. An empty FIFO gives 0.
- R5: `irq` is high exactly while `st_eif` is 1.
- R6: `dma_req` is 1 exactly when at least 8 entries are held and `st_eif` is 0. It returns by itself once the tags have left the window.
- R7: A push into a full FIFO (with no read in the same cycle) is dropped, and the overrun tag of the newest stored entry is set.
- R8: A push and a read in the same cycle are both performed, also when the FIFO is full. All flags reflect the resulting contents after that clock edge.
- R9: After reset the FIFO is empty and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Deserializer delivers a byte this cycle |
| push_data | input | 8 | Received byte |
| push_eof | input | 1 | Byte ends a frame |
| push_crc_err | input | 1 | Frame failed its CRC |
| push_ovr | input | 1 | Receiver overrun at this byte |
| rd_en | input | 1 | CPU reads the data port this cycle |
| rd_data | output | 8 | Oldest byte, 0 when empty |
| st_eof | output | 1 | End-of-frame tag of oldest entry |
| st_crc | output | 1 | CRC-error tag of oldest entry |
| st_ovr | output | 1 | Overrun tag of oldest entry |
| st_eif | output | 1 | A tag lies in the oldest eight entries |
| clr_underflow | input | 1 | Write-one-to-clear for the underflow flag |
| st_underflow | output | 1 | Sticky empty-read flag |
| dma_req | output | 1 | Receive DMA service request |
| irq | output | 1 | End/error interrupt |

## Verification
The hardest situation to reach is a tagged byte that sits just outside the eight-entry window. In that case `dma_req` stays high, and it must drop on the very read that pulls the tag into the window. To reach it, the stimulus pushes eight clean bytes, then one tagged byte, and then checks the flags before and after a single read. A second hard case is the overrun marking on a full FIFO. The stimulus fills all sixteen entries and pushes once more. It then drains the whole FIFO to confirm that only the newest byte carries the new overrun tag and that no extra byte appeared.

// File: rtl/rxtag_pkg.sv
package rxtag_pkg;
    // One FIFO entry: tags above the data byte.
    typedef struct packed {
        logic       ovr;   // bit 10
        logic       crc;   // bit 9
        logic       eof;   // bit 8
        logic [7:0] data;  // bits 7..0
    } rx_entry_t;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_LOW   = 2'd1,
        S_HIGH  = 2'd2,
        S_FULL  = 2'd3
    } occ_state_t;
endpackage

// File: rtl/rxtag_store.sv
module rxtag_store
    import rxtag_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  rx_entry_t             push_ent,
    input  logic                  pop,
    output rx_entry_t             head,
    output logic [DEPTH-1:0][2:0] tags_by_age,
    output logic [CW-1:0]         cnt,
    output logic [CW-1:0]         cnt_nxt,
    output logic                  empty,
    output logic                  full
);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    rx_entry_t        mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic             pop_ok, push_ok, mark_ovr;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CNT_MAX);
    assign pop_ok   = pop & ~empty;
    assign push_ok  = push & (~full | pop_ok);
    assign mark_ovr = push & full & ~pop_ok;

    always_comb begin
        cnt_nxt = cnt;
        if (push_ok && !pop_ok) cnt_nxt = cnt + CW'(1);
        else if (pop_ok && !push_ok) cnt_nxt = cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_ent;
                wr_ptr      <= wr_ptr + PW'(1);
            end
            if (mark_ovr) mem[wr_ptr - PW'(1)].ovr <= 1'b1;
            if (pop_ok) rd_ptr <= rd_ptr + PW'(1);
            cnt <= cnt_nxt;
        end
    end

    assign head = mem[rd_ptr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        logic [PW-1:0] idx;
        assign idx = rd_ptr + PW'(g);
        assign tags_by_age[g] = {mem[idx].ovr, mem[idx].crc, mem[idx].eof};
    end
endmodule

// File: rtl/rxtag_window.sv
module rxtag_window #(
    parameter int DEPTH  = 16,
    parameter int WINDOW = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][2:0] tags_by_age,
    input  logic [CW-1:0]         cnt,
    output logic                  eif
);
    logic [WINDOW-1:0] hit;

    for (genvar g = 0; g < WINDOW; g++) begin : g_win
        assign hit[g] = (CW'(g) < cnt) & (|tags_by_age[g]);
    end

    assign eif = |hit;
endmodule

// File: rtl/rxtag_ctrl.sv
module rxtag_ctrl
    import rxtag_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DMA_LEVEL = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_nxt,
    input  logic          rd_en,
    input  logic          empty,
    input  logic          clr_underflow,
    input  logic          eif,
    output logic          dma_req,
    output logic          irq,
    output logic          underflow
);
    localparam logic [CW-1:0] LVL = CW'(DMA_LEVEL);
    localparam logic [CW-1:0] TOP = CW'(DEPTH);

    occ_state_t state, state_nxt;

    // Transitions named in the brief: fill_start, reach_level, fill_last,
    // drain_one, drop_level, drain_out.
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_EMPTY: if (cnt_nxt != '0) state_nxt = S_LOW;           // fill_start
            S_LOW: begin
                if (cnt_nxt == '0)       state_nxt = S_EMPTY;        // drain_out
                else if (cnt_nxt >= LVL) state_nxt = S_HIGH;         // reach_level
            end
            S_HIGH: begin
                if (cnt_nxt == TOP)      state_nxt = S_FULL;         // fill_last
                else if (cnt_nxt < LVL)  state_nxt = S_LOW;          // drop_level
            end
            S_FULL: if (cnt_nxt != TOP) state_nxt = S_HIGH;          // drain_one
            default: state_nxt = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 underflow <= 1'b0;
        else if (rd_en && empty)    underflow <= 1'b1;
        else if (clr_underflow)     underflow <= 1'b0;
    end

    always_comb begin
        irq = eif;
        unique case (state)
            S_EMPTY, S_LOW: dma_req = 1'b0;
            S_HIGH, S_FULL: dma_req = ~eif;
            default:        dma_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxtag_fifo.sv
module rxtag_fifo
    import rxtag_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WINDOW    = 8,
    parameter int DMA_LEVEL = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  logic [7:0] push_data,
    input  logic       push_eof,
    input  logic       push_crc_err,
    input  logic       push_ovr,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       st_eof,
    output logic       st_crc,
    output logic       st_ovr,
    output logic       st_eif,
    input  logic       clr_underflow,
    output logic       st_underflow,
    output logic       dma_req,
    output logic       irq
);
    rx_entry_t             in_ent, head;
    logic [DEPTH-1:0][2:0] tags_by_age;
    logic [CW-1:0]         cnt_w, cnt_nxt;
    logic                  empty_w, full_w, eif_w;

    assign in_ent = '{ovr: push_ovr, crc: push_crc_err, eof: push_eof, data: push_data};

    rxtag_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push_valid), .push_ent(in_ent),
        .pop(rd_en), .head(head), .tags_by_age(tags_by_age),
        .cnt(cnt_w), .cnt_nxt(cnt_nxt), .empty(empty_w), .full(full_w)
    );

    rxtag_window #(.DEPTH(DEPTH), .WINDOW(WINDOW)) u_window (
        .tags_by_age(tags_by_age), .cnt(cnt_w), .eif(eif_w)
    );

    rxtag_ctrl #(.DEPTH(DEPTH), .DMA_LEVEL(DMA_LEVEL)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .rd_en(rd_en),
        .empty(empty_w), .clr_underflow(clr_underflow), .eif(eif_w),
        .dma_req(dma_req), .irq(irq), .underflow(st_underflow)
    );

    assign rd_data = empty_w ? 8'h00 : head.data;
    assign st_eof  = ~empty_w & head.eof;
    assign st_crc  = ~empty_w & head.crc;
    assign st_ovr  = ~empty_w & head.ovr;
    assign st_eif  = eif_w;
endmodule

// File: rtl/rxtag_fifo_chk.sv
module rxtag_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          rd_en,
    input logic          dma_req,
    input logic          irq,
    input logic          st_underflow,
    input logic [CW-1:0] cnt,
    input logic          full
);
    assert_dma_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> !irq);
    assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !irq);
    assert_underflow_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cnt == '0) |=> st_underflow);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && !rd_en) |=> $stable(cnt));
    assert_pop_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cnt != '0 && !push_valid) |=> (cnt == $past(cnt) - CW'(1)));
    assert_swap_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && push_valid && cnt != '0) |=> $stable(cnt));
    assert_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

bind rxtag_fifo rxtag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .rd_en(rd_en),
    .dma_req(dma_req), .irq(irq), .st_underflow(st_underflow),
    .cnt(cnt_w), .full(full_w)
);

// File: tb/rxtag_fifo_test.sv
module rxtag_fifo_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic push_valid = 0, push_eof = 0, push_crc_err = 0, push_ovr = 0;
    logic [7:0] push_data = '0;
    logic rd_en = 0, clr_underflow = 0;
    logic [7:0] rd_data;
    logic st_eof, st_crc, st_ovr, st_eif, st_underflow, dma_req, irq;

    int checks = 0, errors = 0;
    logic [10:0] q[$];   // scoreboard: {ovr,crc,eof,data}
    logic uf_exp = 1'b0;

    always #5 clk = ~clk;

    rxtag_fifo uut (.*);

    task automatic check(string req, logic [10:0] got, logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic model_eif();
        for (int i = 0; i < q.size() && i < 8; i++)
            if (q[i][10:8] != 3'b000) return 1'b1;
        return 1'b0;
    endfunction

    // Monitor-side comparison of all outputs against the scoreboard head.
    task automatic chk_status();
        logic [10:0] h;
        h = (q.size() > 0) ? q[0] : 11'h0;
        check("R1 rd_data", 11'(rd_data), 11'(h[7:0]));
        check("R2 tags", 11'({st_ovr, st_crc, st_eof}), 11'(h[10:8]));
        check("R4 eif", 11'(st_eif), 11'(model_eif()));
        check("R5 irq", 11'(irq), 11'(model_eif()));
        check("R6 dma", 11'(dma_req), 11'((q.size() >= 8) && !model_eif()));
        check("R3 underflow", 11'(st_underflow), 11'(uf_exp));
    endtask

    task automatic do_push(logic [7:0] d, logic [2:0] t);
        @(negedge clk);
        chk_status();
        push_valid = 1; push_data = d; {push_ovr, push_crc_err, push_eof} = t;
        @(posedge clk); #1;
        push_valid = 0;
        if (q.size() < 16) q.push_back({t, d});
        else q[q.size()-1][10] = 1'b1;   // R7: dropped, newest marked
    endtask

    task automatic do_read();
        @(negedge clk);
        chk_status();
        rd_en = 1;
        @(posedge clk); #1;
        rd_en = 0;
        if (q.size() > 0) void'(q.pop_front());
        else uf_exp = 1'b1;
    endtask

    task automatic do_both(logic [7:0] d, logic [2:0] t);
        @(negedge clk);
        chk_status();
        rd_en = 1; push_valid = 1; push_data = d; {push_ovr, push_crc_err, push_eof} = t;
        @(posedge clk); #1;
        rd_en = 0; push_valid = 0;
        void'(q.pop_front());
        q.push_back({t, d});   // R8: both honoured
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_underflow = 1;
        @(posedge clk); #1;
        clr_underflow = 0;
        uf_exp = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9: reset state
        @(negedge clk);
        check("R9 reset outputs", 11'({rd_data, st_eof, st_crc, st_ovr}), 11'h0);
        check("R9 reset flags", 11'({st_eif, st_underflow, dma_req, irq}), 11'h0);

        // R3: empty read, sticky flag, clear
        do_read();
        do_read();
        @(negedge clk); chk_status();
        do_clear();
        @(negedge clk); chk_status();

        // R6: DMA threshold
        for (int i = 0; i < 8; i++) do_push(8'(8'h10 + i), 3'b000);
        @(negedge clk); chk_status();
        // tag just outside the window: dma stays high
        do_push(8'hA5, 3'b001);
        @(negedge clk); chk_status();
        do_read();   // tag enters window: irq, dma off
        @(negedge clk); chk_status();
        for (int i = 0; i < 8; i++) do_read();   // R2: eof seen before tagged read
        @(negedge clk); chk_status();

        // R7: fill with mixed tags, overflow marks newest
        for (int i = 0; i < 16; i++) do_push(8'(8'h40 + 3 * i), (i % 5 == 2) ? 3'(i % 8) : 3'b000);
        do_push(8'hEE, 3'b000);
        // R8: push+pop while full
        do_both(8'h77, 3'b010);
        do_both(8'h78, 3'b000);
        // R6: drain and see dma come back after tags leave
        for (int i = 0; i < 16; i++) do_read();
        @(negedge clk); chk_status();
        do_read();   // empty again: R3 underflow
        @(negedge clk); chk_status();
        do_clear();

        // R8: simultaneous push/pop at mid level, crc/ovr tags
        do_push(8'h01, 3'b100);
        do_push(8'h02, 3'b010);
        do_both(8'h03, 3'b000);
        do_both(8'h04, 3'b001);
        for (int i = 0; i < 3; i++) do_read();
        @(negedge clk); chk_status();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule